// File: doc/BRIEF.md
# Serial Converter Result Receiver

This block sits beside a successive-approximation converter that reports each result three ways: a gated bit clock, an MSB-first NRZ serial line, and a busy flag held high for the whole conversion. A parallel copy of the same word is also available. The receiver rebuilds the 16-bit word from the serial line and checks it against the parallel copy. It then turns the converter's negative-true code into a plain number. The format of that number depends on how the analog range is wired.

All converter pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and its edges are found in the system clock domain. On every falling edge of the converter clock the synchronised serial bit enters a shift register. A full conversion gives seventeen falling edges. The bit taken on the first edge carries no information, and the seventeenth shift pushes it out of the register. When busy falls, the receiver latches three things: the serial word, the parallel bus and the edge count. One system clock later it presents the decoded word, a one-cycle valid strobe, a frame error flag and a disagreement flag.

Top module: `adc_serial_rx`

## Requirements
- R1: While reset is high and on the first sampling point after it, `word_o`, `valid_o`, `frame_err_o` and `mismatch_o` are all zero.
- R2: For a conversion with seventeen falling clock edges, the bit present on the first falling edge is discarded. The bits present on falling edges two to seventeen form the line code, from bit 15 down to bit 0.
- R3: With `fmt_i` = 0 (unipolar), and also with the spare value 3, `word_o` is the bitwise inverse of the line code.
- R4: With `fmt_i` = 1 (bipolar), `word_o` is the bitwise inverse of the line code with bit 15 inverted again, giving two's complement.
- R5: With `fmt_i` = 2, `word_o` is the line code unchanged.
- R6: `valid_o` is high for exactly one system clock cycle per conversion. It rises on the fourth rising system clock edge after the busy input falls.
- R7: `frame_err_o` is 1 when the number of converter clock falling edges counted since busy last rose is not seventeen, and 0 when it is seventeen.
- R8: `mismatch_o` is 1 exactly when the parallel bus value present when busy falls differs from the serial line code.
- R9: A converter clock falling edge that reaches the receiver in the same cycle as the busy falling edge is counted and shifted in before the word is latched.
- R10: Between valid strobes, `word_o`, `frame_err_o` and `mismatch_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_sclk_i | input | 1 | Gated bit clock from the converter |
| conv_sdat_i | input | 1 | Serial data line, changes on converter clock rising edges |
| conv_busy_i | input | 1 | High while a conversion runs |
| conv_par_i | input | 16 | Parallel result bus, negative-true |
| fmt_i | input | 2 | Output format: 0 unipolar, 1 bipolar two's complement, 2 raw line code |
| word_o | output | 16 | Decoded result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Falling-edge count of the last conversion was not seventeen |
| mismatch_o | output | 1 | Serial and parallel results disagreed |

## Verification
A shift register off by one position shows in every result as a word shifted by one bit, with the junk bit in the LSB or the MSB lost. This is visible four cycles after busy falls. An edge counter that misses the final edge, or is not cleared when busy rises, shows as a false or missing frame error on the next conversion. An inversion error in the decoder shows as a wrong word for one format alone. Cycling every format against codes near zero, midscale and full scale exposes it at once.

// File: rtl/adc_rx_pkg.sv
`timescale 1ns/1ps
package adc_rx_pkg;
  typedef enum logic [1:0] {
    FMT_STRAIGHT = 2'd0,
    FMT_TWOS     = 2'd1,
    FMT_LINE     = 2'd2,
    FMT_SPARE    = 2'd3
  } fmt_e;
endpackage

// File: rtl/adc_rx_sync.sv
`timescale 1ns/1ps
module adc_rx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_rx_capture.sv
`timescale 1ns/1ps
module adc_rx_capture #(
  parameter int W     = 16,
  parameter int EDGES = W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdat_s,
  input  logic         busy_s,
  input  logic [W-1:0] par_s,
  output logic         cap_v,
  output logic [W-1:0] ser_word,
  output logic [W-1:0] par_word,
  output logic         edge_err
);
  localparam int CW = $clog2(EDGES + 2);
  localparam logic [CW-1:0] CMAX    = '1;
  localparam logic [CW-1:0] EXPECTC = CW'(EDGES);

  logic          sclk_q, busy_q;
  logic          sclk_fall, busy_rise, busy_fall;
  logic [W-1:0]  shreg, sh_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign busy_rise = ~busy_q & busy_s;
  assign busy_fall = busy_q & ~busy_s;

  always_comb begin
    sh_nxt  = sclk_fall ? {shreg[W-2:0], sdat_s} : shreg;
    cnt_nxt = cnt;
    if (busy_rise)                      cnt_nxt = '0;
    else if (sclk_fall && cnt != CMAX)  cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      busy_q   <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      cap_v    <= 1'b0;
      ser_word <= '0;
      par_word <= '0;
      edge_err <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      busy_q <= busy_s;
      shreg  <= sh_nxt;
      cnt    <= cnt_nxt;
      cap_v  <= busy_fall;
      if (busy_fall) begin
        ser_word <= sh_nxt;
        par_word <= par_s;
        edge_err <= (cnt_nxt != EXPECTC);
      end
    end
  end
endmodule

// File: rtl/adc_rx_decode.sv
`timescale 1ns/1ps
module adc_rx_decode #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_v,
  input  logic [W-1:0]     ser_word,
  input  logic [W-1:0]     par_word,
  input  logic             edge_err,
  input  adc_rx_pkg::fmt_e fmt,
  output logic [W-1:0]     word_o,
  output logic             valid_o,
  output logic             frame_err_o,
  output logic             mismatch_o
);
  localparam logic [W-1:0] SIGN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] dec;

  always_comb begin
    case (fmt)
      adc_rx_pkg::FMT_TWOS: dec = ~ser_word ^ SIGN;
      adc_rx_pkg::FMT_LINE: dec = ser_word;
      default:              dec = ~ser_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      mismatch_o  <= 1'b0;
    end else begin
      valid_o <= cap_v;
      if (cap_v) begin
        word_o      <= dec;
        frame_err_o <= edge_err;
        mismatch_o  <= (ser_word != par_word);
      end
    end
  end
endmodule

// File: rtl/adc_serial_rx.sv
`timescale 1ns/1ps
module adc_serial_rx #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_sclk_i,
  input  logic         conv_sdat_i,
  input  logic         conv_busy_i,
  input  logic [W-1:0] conv_par_i,
  input  logic [1:0]   fmt_i,
  output logic [W-1:0] word_o,
  output logic         valid_o,
  output logic         frame_err_o,
  output logic         mismatch_o
);
  localparam int EDGES = W + 1;

  logic [2:0]       ctl_s;
  logic [W-1:0]     par_s;
  logic             cap_v, edge_err;
  logic [W-1:0]     ser_word, par_word;
  adc_rx_pkg::fmt_e fmt_w;

  assign fmt_w = adc_rx_pkg::fmt_e'(fmt_i);

  adc_rx_sync #(.W(3), .STAGES(STAGES)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({conv_busy_i, conv_sdat_i, conv_sclk_i}),
    .q(ctl_s)
  );

  adc_rx_sync #(.W(W), .STAGES(STAGES)) u_sync_par (
    .clk(clk), .rst(rst), .d(conv_par_i), .q(par_s)
  );

  adc_rx_capture #(.W(W), .EDGES(EDGES)) u_cap (
    .clk(clk), .rst(rst),
    .sclk_s(ctl_s[0]), .sdat_s(ctl_s[1]), .busy_s(ctl_s[2]),
    .par_s(par_s),
    .cap_v(cap_v), .ser_word(ser_word), .par_word(par_word),
    .edge_err(edge_err)
  );

  adc_rx_decode #(.W(W)) u_dec (
    .clk(clk), .rst(rst),
    .cap_v(cap_v), .ser_word(ser_word), .par_word(par_word),
    .edge_err(edge_err), .fmt(fmt_w),
    .word_o(word_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o), .mismatch_o(mismatch_o)
  );
endmodule

// File: rtl/adc_serial_rx_chk.sv
`timescale 1ns/1ps
module adc_serial_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         valid,
  input logic [W-1:0] word,
  input logic         ferr,
  input logic         mism,
  input logic         cap
);
  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_valid_follows_capture_r6: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(cap));

  p_word_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(word));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable({ferr, mism}));
endmodule

bind adc_serial_rx adc_serial_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .valid(valid_o), .word(word_o),
  .ferr(frame_err_o), .mism(mismatch_o), .cap(cap_v)
);

// File: tb/tb_adc_serial_rx.sv
`timescale 1ns/1ps
module tb_adc_serial_rx;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sdat = 1'b0, busy = 1'b0;
  logic [15:0] par_i = '0;
  logic [1:0]  fmt_i = '0;
  logic [15:0] word_o;
  logic        valid_o, frame_err_o, mismatch_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_serial_rx dut (
    .clk(clk), .rst(rst),
    .conv_sclk_i(sclk), .conv_sdat_i(sdat), .conv_busy_i(busy),
    .conv_par_i(par_i), .fmt_i(fmt_i),
    .word_o(word_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o), .mismatch_o(mismatch_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] code, input logic [1:0] fmt);
    case (fmt)
      2'd1:    return ~code ^ 16'h8000;
      2'd2:    return code;
      default: return ~code;
    endcase
  endfunction

  function automatic string fmt_req(input logic [1:0] fmt);
    case (fmt)
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic conv(input logic [15:0] code, input int nedg, input bit same,
                      input bit flip, input logic [1:0] fmt);
    logic [15:0] pv, got;
    logic [4:0]  vis;
    logic        fe, mm;
    string       tag;
    pv = flip ? (code ^ (16'h1 << ($urandom % 16))) : code;
    @(negedge clk);
    fmt_i = fmt; par_i = pv; busy = 1'b1;
    repeat (H) @(negedge clk);
    for (int k = 0; k < nedg; k++) begin
      sclk = 1'b1;
      if (k < nedg - 16) sdat = 1'($urandom);
      else               sdat = code[15 - (k - (nedg - 16))];
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      if (k == nedg - 1 && same) busy = 1'b0;
      else repeat (H) @(negedge clk);
    end
    if (!same) busy = 1'b0;
    vis = '0; got = '0; fe = 1'b0; mm = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      vis[n-1] = valid_o;
      if (n == 4) begin got = word_o; fe = frame_err_o; mm = mismatch_o; end
    end
    tag = same ? "R9" : "R2";
    chk("R6 valid timing", 32'(vis), 32'(5'b01000));
    if (nedg == 17) chk({tag, " ", fmt_req(fmt), " word"}, 32'(got), 32'(exp_word(code, fmt)));
    chk({"R7 frame error ", tag}, 32'(fe), 32'(nedg != 17));
    chk("R8 mismatch", 32'(mm), 32'(flip));
    par_i = ~par_i;
    repeat (3) @(negedge clk);
    chk("R10 hold", {14'd0, frame_err_o, mismatch_o, word_o}, {14'd0, fe, mm, got});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset", {13'd0, valid_o, frame_err_o, mismatch_o, word_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {13'd0, valid_o, frame_err_o, mismatch_o, word_o}, 32'd0);

    conv(16'h0000, 17, 0, 0, 2'd0);
    conv(16'hFFFF, 17, 0, 0, 2'd0);
    conv(16'h7FFF, 17, 0, 0, 2'd1);
    conv(16'h8000, 17, 0, 0, 2'd1);
    conv(16'hFFFF, 17, 0, 0, 2'd1);
    conv(16'h3A5C, 17, 0, 0, 2'd2);
    conv(16'hC3A1, 17, 0, 0, 2'd3);
    conv(16'h1234, 17, 1, 0, 2'd0);
    conv(16'h5555, 16, 0, 0, 2'd0);
    conv(16'hAAAA, 18, 0, 0, 2'd0);
    conv(16'h0F0F, 17, 0, 1, 2'd1);
    conv(16'h0001, 17, 0, 0, 2'd0);

    for (int i = 0; i < 40; i++) begin
      int r = int'($urandom % 10);
      conv(16'($urandom), (r == 0) ? 16 : (r == 1) ? 18 : 17,
           ($urandom % 4) == 0, ($urandom % 8) == 0, 2'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule